// File: doc/BRIEF.md
# Free-Buffer Token Pool Manager

This block holds free-buffer tokens in a set of independent pools, each selected by a pool index. Requesters on several command ports either take a token from a pool (acquire) or hand one back (release). A token is an opaque value, normally a buffer address. Software seeds a pool at any time by releasing any values it likes into it. Allocation is last-in-first-out, so the token handed back most recently is the next one given out. Because of this, a freshly freed buffer is reused while its lines are likely still cached.

Each pool keeps a small on-chip circular stack of tokens. The stack is kept inside a comfort band between a low and a high watermark. When a stack rises above the band, a transfer engine writes its oldest entries out to a backing store in a fixed burst. When a stack drops below the band and the backing store holds tokens for that pool, the engine reads them back. The transfer engine serves one pool at a time. The backing store is modelled by a simple request/response port. Each pool also drives a depletion flag with hysteresis.

Top module: `bpm_top`

## Requirements
- R1: Every command acts only on the pool named by its pool index. Tokens released into one pool are never returned by an acquire from another.
- R2: `req_op` encodes 0 = acquire and 1 = release. A command completes in the cycle where `req_valid` and `req_ready` are both high. One cycle later `resp_valid` is high, with `resp_port` giving the completing port. A release answers `resp_ok`=1.
- R3: Within a pool, acquires return tokens in reverse order of release. This holds across tokens that went out to the backing store and came back.
- R4: An acquire from a pool whose on-chip stack and backing store are both empty completes with `resp_ok`=0 and `resp_token`=0.
- R5: Command ports are arbitrated round-robin. At most one handshake occurs per cycle, and only to a port with `req_valid` high. Two ports that request continuously are granted alternately.
- R6: When a pool's on-chip count exceeds HIGH_WM (55), the engine writes exactly BURST (8) tokens of that pool with `mem_req_write`=1. The oldest on-chip token goes first.
- R7: When a pool's on-chip count is below LOW_WM (16) and its backing store is non-empty, the engine reads back min(BURST, backing count) tokens with `mem_req_write`=0. Each token returns on `mem_rsp_valid`.
- R8: A backing-store request held while `mem_req_ready` is low keeps its valid, direction, pool and data unchanged.
- R9: `depleted[i]` is 1 after reset. It becomes 1 when the pool's total count (on chip plus backing) is below DEP_ENTER (4). It returns to 0 only when that total exceeds DEP_EXIT (8). Between those thresholds it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_PORTS | Command present, per port |
| req_op | input | NUM_PORTS | 0 acquire, 1 release, per port |
| req_pool | input | NUM_PORTS x PID_W | Pool index per port |
| req_token | input | NUM_PORTS x TOK_W | Token to release per port |
| req_ready | output | NUM_PORTS | One-hot command accept |
| resp_valid | output | 1 | Response present |
| resp_port | output | PORT_W | Port the response belongs to |
| resp_ok | output | 1 | 1 = success, 0 = acquire from empty pool |
| resp_token | output | TOK_W | Acquired token, 0 otherwise |
| mem_req_valid | output | 1 | Backing-store request |
| mem_req_ready | input | 1 | Backing store accepts request |
| mem_req_write | output | 1 | 1 = store token, 0 = fetch token |
| mem_req_pool | output | PID_W | Pool of the request |
| mem_req_wdata | output | TOK_W | Token being stored |
| mem_rsp_valid | input | 1 | Fetched token returned |
| mem_rsp_data | input | TOK_W | Fetched token value |
| depleted | output | NUM_POOLS | Per-pool depletion flag |

## Verification
A wrong stack base or count shows up at the response port on the very next acquire of that pool, as a token out of reverse release order. A spill that takes the top of the stack instead of the bottom stays hidden until the refill. It then appears as a misordered token at the acquire where the on-chip and refilled tokens meet. An off-by-one in burst length or backing count shows in the number of backing-store writes and reads. It also shows as an early or missing failure response once the pool drains. Flag errors show on `depleted` two cycles after the count crosses a threshold.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

    typedef enum logic [1:0] {
        XF_IDLE,
        XF_SPILL,
        XF_RD_REQ,
        XF_RD_WAIT
    } xfer_state_e;

    typedef enum logic {
        OP_ACQUIRE = 1'b0,
        OP_RELEASE = 1'b1
    } op_e;

    function automatic int idx_w(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bpm_rr_arb.sv
module bpm_rr_arb #(
    parameter int N = 2,
    localparam int IW = bpm_pkg::idx_w(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          advance,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx,
    output logic          any
);
    logic [IW-1:0] ptr_q;

    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        any     = 1'b0;
        for (int i = 0; i < N; i++) begin
            int j;
            j = int'(ptr_q) + i;
            if (j >= N) j = j - N;
            if (!any && req[j]) begin
                any     = 1'b1;
                gnt[j]  = 1'b1;
                gnt_idx = IW'(j);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (advance && any) begin
            ptr_q <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + IW'(1);
        end
    end
endmodule

// File: rtl/bpm_pool_store.sv
module bpm_pool_store #(
    parameter int NUM_POOLS = 4,
    parameter int DEPTH     = 64,
    parameter int TOK_W     = 16,
    parameter int EXT_W     = 16,
    localparam int PID_W    = bpm_pkg::idx_w(NUM_POOLS),
    localparam int PTR_W    = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cmd_push,
    input  logic                              cmd_pop,
    input  logic [PID_W-1:0]                  cmd_pool,
    input  logic [TOK_W-1:0]                  cmd_data,
    input  logic                              eng_push,
    input  logic                              eng_pop,
    input  logic [PID_W-1:0]                  eng_pool,
    input  logic [TOK_W-1:0]                  eng_data,
    output logic [NUM_POOLS-1:0][CNT_W-1:0]   cnt_o,
    output logic [NUM_POOLS-1:0][EXT_W-1:0]   ext_o,
    output logic [TOK_W-1:0]                  top_data,
    output logic [TOK_W-1:0]                  bot_data
);
    logic [TOK_W-1:0]                  stk_q [NUM_POOLS][DEPTH];
    logic [NUM_POOLS-1:0][PTR_W-1:0]   base_q;
    logic [NUM_POOLS-1:0][CNT_W-1:0]   cnt_q;
    logic [NUM_POOLS-1:0][EXT_W-1:0]   ext_q;

    logic [PTR_W-1:0] cmd_top_idx, cmd_put_idx, eng_put_idx;

    // Circular stack: bottom at base, top at base+cnt-1 (wraps modulo DEPTH)
    assign cmd_put_idx = base_q[cmd_pool] + cnt_q[cmd_pool][PTR_W-1:0];
    assign cmd_top_idx = cmd_put_idx - PTR_W'(1);
    assign eng_put_idx = base_q[eng_pool] - PTR_W'(1);

    assign top_data = stk_q[cmd_pool][cmd_top_idx];
    assign bot_data = stk_q[eng_pool][base_q[eng_pool]];
    assign cnt_o    = cnt_q;
    assign ext_o    = ext_q;

    always_ff @(posedge clk) begin
        if (cmd_push) stk_q[cmd_pool][cmd_put_idx] <= cmd_data;
        if (eng_push) stk_q[eng_pool][eng_put_idx] <= eng_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
            ext_q  <= '0;
        end else begin
            // command side and engine side never address the same pool
            if (cmd_push) cnt_q[cmd_pool] <= cnt_q[cmd_pool] + CNT_W'(1);
            if (cmd_pop)  cnt_q[cmd_pool] <= cnt_q[cmd_pool] - CNT_W'(1);
            if (eng_pop) begin
                base_q[eng_pool] <= base_q[eng_pool] + PTR_W'(1);
                cnt_q[eng_pool]  <= cnt_q[eng_pool] - CNT_W'(1);
                ext_q[eng_pool]  <= ext_q[eng_pool] + EXT_W'(1);
            end
            if (eng_push) begin
                base_q[eng_pool] <= eng_put_idx;
                cnt_q[eng_pool]  <= cnt_q[eng_pool] + CNT_W'(1);
                ext_q[eng_pool]  <= ext_q[eng_pool] - EXT_W'(1);
            end
        end
    end
endmodule

// File: rtl/bpm_xfer_engine.sv
module bpm_xfer_engine #(
    parameter int NUM_POOLS = 4,
    parameter int DEPTH     = 64,
    parameter int TOK_W     = 16,
    parameter int EXT_W     = 16,
    parameter int LOW_WM    = 16,
    parameter int HIGH_WM   = 55,
    parameter int BURST     = 8,
    localparam int PID_W    = bpm_pkg::idx_w(NUM_POOLS),
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int BW       = $clog2(BURST + 1)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_POOLS-1:0][CNT_W-1:0]   cnt_i,
    input  logic [NUM_POOLS-1:0][EXT_W-1:0]   ext_i,
    input  logic [TOK_W-1:0]                  bot_data,
    input  logic                              mem_req_ready,
    input  logic                              mem_rsp_valid,
    input  logic [TOK_W-1:0]                  mem_rsp_data,
    output logic                              mem_req_valid,
    output logic                              mem_req_write,
    output logic [PID_W-1:0]                  mem_req_pool,
    output logic [TOK_W-1:0]                  mem_req_wdata,
    output logic                              eng_push,
    output logic                              eng_pop,
    output logic [TOK_W-1:0]                  eng_data,
    output logic                              busy,
    output logic [PID_W-1:0]                  eng_pool
);
    import bpm_pkg::*;

    xfer_state_e      state_q;
    logic [PID_W-1:0] pool_q;
    logic [BW-1:0]    beat_q, target_q;
    logic             last_beat;

    logic [NUM_POOLS-1:0] need_spill, need_fill, pick;
    logic [PID_W-1:0]     pick_idx;
    logic                 pick_any, pick_spill;

    for (genvar g = 0; g < NUM_POOLS; g++) begin : g_need
        assign need_spill[g] = cnt_i[g] > CNT_W'(HIGH_WM);
        assign need_fill[g]  = (cnt_i[g] < CNT_W'(LOW_WM)) && (ext_i[g] != '0);
    end

    bpm_rr_arb #(.N(NUM_POOLS)) u_pool_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (need_spill | need_fill),
        .advance (state_q == XF_IDLE),
        .gnt     (pick),
        .gnt_idx (pick_idx),
        .any     (pick_any)
    );

    assign pick_spill = |(pick & need_spill);
    assign last_beat  = (beat_q == target_q - BW'(1));

    assign busy          = (state_q != XF_IDLE);
    assign eng_pool      = pool_q;
    assign mem_req_pool  = pool_q;
    assign mem_req_valid = (state_q == XF_SPILL) || (state_q == XF_RD_REQ);
    assign mem_req_write = (state_q == XF_SPILL);
    assign mem_req_wdata = bot_data;
    assign eng_pop       = (state_q == XF_SPILL) && mem_req_ready;
    assign eng_push      = (state_q == XF_RD_WAIT) && mem_rsp_valid;
    assign eng_data      = mem_rsp_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= XF_IDLE;
            pool_q   <= '0;
            beat_q   <= '0;
            target_q <= '0;
        end else begin
            unique case (state_q)
                XF_IDLE: if (pick_any) begin
                    pool_q <= pick_idx;
                    beat_q <= '0;
                    if (pick_spill) begin
                        state_q  <= XF_SPILL;
                        target_q <= BW'(BURST);
                    end else begin
                        state_q  <= XF_RD_REQ;
                        target_q <= (ext_i[pick_idx] >= EXT_W'(BURST)) ? BW'(BURST)
                                                                        : BW'(ext_i[pick_idx]);
                    end
                end
                XF_SPILL: if (mem_req_ready) begin
                    beat_q <= beat_q + BW'(1);
                    if (last_beat) state_q <= XF_IDLE;
                end
                XF_RD_REQ: if (mem_req_ready) state_q <= XF_RD_WAIT;
                XF_RD_WAIT: if (mem_rsp_valid) begin
                    beat_q  <= beat_q + BW'(1);
                    state_q <= last_beat ? XF_IDLE : XF_RD_REQ;
                end
                default: state_q <= XF_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bpm_top.sv
module bpm_top #(
    parameter int NUM_POOLS = 4,
    parameter int NUM_PORTS = 2,
    parameter int TOK_W     = 16,
    parameter int DEPTH     = 64,
    parameter int LOW_WM    = 16,
    parameter int HIGH_WM   = 55,
    parameter int BURST     = 8,
    parameter int EXT_W     = 16,
    parameter int DEP_ENTER = 4,
    parameter int DEP_EXIT  = 8,
    localparam int PID_W    = bpm_pkg::idx_w(NUM_POOLS),
    localparam int PORT_W   = bpm_pkg::idx_w(NUM_PORTS),
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_PORTS-1:0]             req_valid,
    input  logic [NUM_PORTS-1:0]             req_op,
    input  logic [NUM_PORTS-1:0][PID_W-1:0]  req_pool,
    input  logic [NUM_PORTS-1:0][TOK_W-1:0]  req_token,
    output logic [NUM_PORTS-1:0]             req_ready,
    output logic                             resp_valid,
    output logic [PORT_W-1:0]                resp_port,
    output logic                             resp_ok,
    output logic [TOK_W-1:0]                 resp_token,
    output logic                             mem_req_valid,
    input  logic                             mem_req_ready,
    output logic                             mem_req_write,
    output logic [PID_W-1:0]                 mem_req_pool,
    output logic [TOK_W-1:0]                 mem_req_wdata,
    input  logic                             mem_rsp_valid,
    input  logic [TOK_W-1:0]                 mem_rsp_data,
    output logic [NUM_POOLS-1:0]             depleted
);
    import bpm_pkg::*;

    typedef struct packed {
        logic              valid;
        logic [PORT_W-1:0] port;
        logic              ok;
        logic [TOK_W-1:0]  token;
    } resp_t;

    logic [NUM_POOLS-1:0][CNT_W-1:0] cnt;
    logic [NUM_POOLS-1:0][EXT_W-1:0] ext;
    logic [TOK_W-1:0] top_data, bot_data, eng_data;
    logic             eng_push, eng_pop, eng_busy;
    logic [PID_W-1:0] eng_pool;

    logic [NUM_PORTS-1:0] eligible;
    logic [PORT_W-1:0]    sel;
    logic                 cmd_any, cmd_rel, cmd_has;
    logic [PID_W-1:0]     cmd_pool;
    resp_t                resp_q;
    logic [NUM_POOLS-1:0] dep_q;

    // A port is eligible when its pool is not in transfer and the op can progress
    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            logic [PID_W-1:0] pl;
            logic             go;
            pl = req_pool[p];
            if (req_op[p] == OP_RELEASE) go = (cnt[pl] != CNT_W'(DEPTH));
            else                         go = (cnt[pl] != '0) || (ext[pl] == '0);
            eligible[p] = req_valid[p] && go && !(eng_busy && (eng_pool == pl));
        end
    end

    bpm_rr_arb #(.N(NUM_PORTS)) u_port_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (eligible),
        .advance (1'b1),
        .gnt     (req_ready),
        .gnt_idx (sel),
        .any     (cmd_any)
    );

    assign cmd_pool = req_pool[sel];
    assign cmd_rel  = (req_op[sel] == OP_RELEASE);
    assign cmd_has  = (cnt[cmd_pool] != '0);

    bpm_pool_store #(
        .NUM_POOLS (NUM_POOLS),
        .DEPTH     (DEPTH),
        .TOK_W     (TOK_W),
        .EXT_W     (EXT_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .cmd_push (cmd_any && cmd_rel),
        .cmd_pop  (cmd_any && !cmd_rel && cmd_has),
        .cmd_pool (cmd_pool),
        .cmd_data (req_token[sel]),
        .eng_push (eng_push),
        .eng_pop  (eng_pop),
        .eng_pool (eng_pool),
        .eng_data (eng_data),
        .cnt_o    (cnt),
        .ext_o    (ext),
        .top_data (top_data),
        .bot_data (bot_data)
    );

    bpm_xfer_engine #(
        .NUM_POOLS (NUM_POOLS),
        .DEPTH     (DEPTH),
        .TOK_W     (TOK_W),
        .EXT_W     (EXT_W),
        .LOW_WM    (LOW_WM),
        .HIGH_WM   (HIGH_WM),
        .BURST     (BURST)
    ) u_engine (
        .clk           (clk),
        .rst           (rst),
        .cnt_i         (cnt),
        .ext_i         (ext),
        .bot_data      (bot_data),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_req_valid (mem_req_valid),
        .mem_req_write (mem_req_write),
        .mem_req_pool  (mem_req_pool),
        .mem_req_wdata (mem_req_wdata),
        .eng_push      (eng_push),
        .eng_pop       (eng_pop),
        .eng_data      (eng_data),
        .busy          (eng_busy),
        .eng_pool      (eng_pool)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '0;
        end else begin
            resp_q.valid <= cmd_any;
            resp_q.port  <= sel;
            resp_q.ok    <= cmd_rel || cmd_has;
            resp_q.token <= (!cmd_rel && cmd_has) ? top_data : '0;
        end
    end

    assign resp_valid = resp_q.valid;
    assign resp_port  = resp_q.port;
    assign resp_ok    = resp_q.ok;
    assign resp_token = resp_q.token;

    for (genvar g = 0; g < NUM_POOLS; g++) begin : g_dep
        logic [EXT_W:0] total;
        assign total = {1'b0, ext[g]} + (EXT_W + 1)'(cnt[g]);
        always_ff @(posedge clk) begin
            if (rst)                                   dep_q[g] <= 1'b1;
            else if (total < (EXT_W + 1)'(DEP_ENTER))  dep_q[g] <= 1'b1;
            else if (total > (EXT_W + 1)'(DEP_EXIT))   dep_q[g] <= 1'b0;
        end
    end

    assign depleted = dep_q;
endmodule

// File: rtl/bpm_checker.sv
module bpm_checker #(
    parameter int NUM_PORTS = 2,
    parameter int PID_W     = 2,
    parameter int TOK_W     = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_PORTS-1:0] req_valid,
    input logic [NUM_PORTS-1:0] req_ready,
    input logic                 resp_valid,
    input logic                 resp_ok,
    input logic [TOK_W-1:0]     resp_token,
    input logic                 mem_req_valid,
    input logic                 mem_req_ready,
    input logic                 mem_req_write,
    input logic [PID_W-1:0]     mem_req_pool,
    input logic [TOK_W-1:0]     mem_req_wdata
);
    // R5
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_ready));

    // R5
    grant_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (req_ready & ~req_valid) == '0);

    // R2
    resp_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (|req_ready) |=> resp_valid);

    // R2
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !(|req_ready) |=> !resp_valid);

    // R4
    fail_token_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_ok) |-> (resp_token == '0));

    // R8
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_write) && $stable(mem_req_pool)
             && $stable(mem_req_wdata)));
endmodule

bind bpm_top bpm_checker #(
    .NUM_PORTS (NUM_PORTS),
    .PID_W     (PID_W),
    .TOK_W     (TOK_W)
) u_bpm_checker (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .resp_valid    (resp_valid),
    .resp_ok       (resp_ok),
    .resp_token    (resp_token),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_pool  (mem_req_pool),
    .mem_req_wdata (mem_req_wdata)
);

// File: tb/tb_bpm_top.sv
module tb_bpm_top;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        req_valid = '0;
    logic [1:0]        req_op = '0;
    logic [1:0][1:0]   req_pool = '0;
    logic [1:0][15:0]  req_token = '0;
    logic [1:0]        req_ready;
    logic              resp_valid;
    logic [0:0]        resp_port;
    logic              resp_ok;
    logic [15:0]       resp_token;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic              mem_req_write;
    logic [1:0]        mem_req_pool;
    logic [15:0]       mem_req_wdata;
    logic              mem_rsp_valid = 1'b0;
    logic [15:0]       mem_rsp_data = '0;
    logic [3:0]        depleted;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    bpm_top dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_op(req_op), .req_pool(req_pool), .req_token(req_token),
        .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_port(resp_port), .resp_ok(resp_ok), .resp_token(resp_token),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_pool(mem_req_pool), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .depleted(depleted)
    );

    // Backing-store model: per-pool stack, ready two cycles of three, read latency 2
    logic [15:0] bstk [4][64];
    int          bcnt [4] = '{0, 0, 0, 0};
    int          wr_cnt [4] = '{0, 0, 0, 0};
    int          rd_cnt [4] = '{0, 0, 0, 0};
    int          rd_wait = 0;
    int          rdy_ctr = 0;
    logic [15:0] rd_tok = '0;

    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (rd_wait > 0) begin
            rd_wait = rd_wait - 1;
            if (rd_wait == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rd_tok;
            end
        end
        rdy_ctr = rdy_ctr + 1;
        mem_req_ready = (rdy_ctr % 3) != 0;
        if (!rst && mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                bstk[mem_req_pool][bcnt[mem_req_pool]] = mem_req_wdata;
                bcnt[mem_req_pool]   = bcnt[mem_req_pool] + 1;
                wr_cnt[mem_req_pool] = wr_cnt[mem_req_pool] + 1;
            end else begin
                bcnt[mem_req_pool]   = bcnt[mem_req_pool] - 1;
                rd_tok               = bstk[mem_req_pool][bcnt[mem_req_pool]];
                rd_cnt[mem_req_pool] = rd_cnt[mem_req_pool] + 1;
                rd_wait              = 2;
            end
        end
    end

    task automatic chk(input bit cond, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    task automatic cmd(input int p, input bit op, input int pool, input logic [15:0] tok,
                       output bit ok, output logic [15:0] rtok);
        @(negedge clk);
        req_valid[p] = 1'b1;
        req_op[p]    = op;
        req_pool[p]  = 2'(pool);
        req_token[p] = tok;
        #1;
        while (!req_ready[p]) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid[p] = 1'b0;
        chk(resp_valid && resp_port == 1'(p), "R2", "response valid/port",
            {resp_valid, 7'(resp_port)}, {1'b1, 7'(p)});
        ok   = resp_ok;
        rtok = resp_token;
    endtask

    task automatic release_tok(input int p, input int pool, input logic [15:0] tok);
        bit ok; logic [15:0] t;
        cmd(p, 1'b1, pool, tok, ok, t);
        chk(ok, "R2", "release ok", ok, 1);
    endtask

    task automatic acquire_exp(input int p, input int pool, input logic [15:0] exp, input string req);
        bit ok; logic [15:0] t;
        cmd(p, 1'b0, pool, 16'h0, ok, t);
        chk(ok && t == exp, req, "acquired token", t, exp);
    endtask

    task automatic acquire_fail(input int pool);
        bit ok; logic [15:0] t;
        cmd(0, 1'b0, pool, 16'h0, ok, t);
        chk(!ok && t == 16'h0, "R4", "empty-pool acquire ok/token", {ok, t}, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!resp_valid, "R2", "resp_valid after reset", resp_valid, 0);
        chk(!mem_req_valid, "R6", "mem_req_valid after reset", mem_req_valid, 0);
        chk(depleted == 4'hF, "R9", "depleted after reset", depleted, 4'hF);
    endtask

    task automatic t_lifo();
        release_tok(0, 1, 16'hA001);
        release_tok(0, 1, 16'hA002);
        release_tok(0, 1, 16'hA003);
        release_tok(1, 0, 16'hB001);
        acquire_exp(1, 1, 16'hA003, "R3");
        acquire_exp(0, 1, 16'hA002, "R3");
        acquire_exp(0, 0, 16'hB001, "R1");
        acquire_exp(0, 1, 16'hA001, "R3");
        acquire_fail(1);
        acquire_fail(0);
    endtask

    task automatic t_arb();
        int c0 = 0, c1 = 0, prev = -1, gp;
        @(negedge clk);
        req_valid = 2'b11;
        req_op    = 2'b11;
        req_pool[0] = 2'd0; req_token[0] = 16'hC000;
        req_pool[1] = 2'd2; req_token[1] = 16'hD000;
        for (int k = 0; k < 6; k++) begin
            #1;
            chk($countones(req_ready) == 1, "R5", "grants per cycle", $countones(req_ready), 1);
            gp = req_ready[1] ? 1 : 0;
            if (prev >= 0) chk(gp != prev, "R5", "alternating grant port", gp, 1 - prev);
            prev = gp;
            @(negedge clk);
            if (gp == 0) begin c0++; req_token[0] = 16'hC000 + 16'(c0); end
            else         begin c1++; req_token[1] = 16'hD000 + 16'(c1); end
        end
        req_valid = 2'b00;
        for (int k = 2; k >= 0; k--) acquire_exp(0, 0, 16'hC000 + 16'(k), "R5");
        for (int k = 2; k >= 0; k--) acquire_exp(1, 2, 16'hD000 + 16'(k), "R1");
    endtask

    task automatic t_depletion();
        for (int k = 0; k < 5; k++) release_tok(0, 1, 16'hF000 + 16'(k));
        repeat (3) @(negedge clk);
        chk(depleted[1], "R9", "flag held at total 5 (not above exit)", depleted[1], 1);
        for (int k = 5; k < 9; k++) release_tok(1, 1, 16'hF000 + 16'(k));
        repeat (3) @(negedge clk);
        chk(!depleted[1], "R9", "flag cleared at total 9", depleted[1], 0);
        for (int k = 8; k >= 5; k--) acquire_exp(0, 1, 16'hF000 + 16'(k), "R9");
        repeat (3) @(negedge clk);
        chk(!depleted[1], "R9", "flag stays clear at total 5", depleted[1], 0);
        for (int k = 4; k >= 3; k--) acquire_exp(0, 1, 16'hF000 + 16'(k), "R9");
        repeat (3) @(negedge clk);
        chk(depleted[1], "R9", "flag set at total 3", depleted[1], 1);
        for (int k = 2; k >= 0; k--) acquire_exp(0, 1, 16'hF000 + 16'(k), "R9");
    endtask

    task automatic t_spill_refill();
        for (int k = 0; k < 56; k++) release_tok(k % 2, 3, 16'hE000 + 16'(k));
        repeat (40) @(negedge clk);
        chk(wr_cnt[3] == 8, "R6", "backing writes for pool 3", wr_cnt[3], 8);
        chk(bcnt[3] == 8, "R6", "backing depth for pool 3", bcnt[3], 8);
        chk(bstk[3][0] == 16'hE000, "R6", "oldest token spilled first", bstk[3][0], 16'hE000);
        chk(wr_cnt[0] + wr_cnt[1] + wr_cnt[2] == 0, "R1", "no spill on other pools",
            wr_cnt[0] + wr_cnt[1] + wr_cnt[2], 0);
        chk(!depleted[3], "R9", "full pool not depleted", depleted[3], 0);
        for (int k = 55; k >= 0; k--) acquire_exp(k % 2, 3, 16'hE000 + 16'(k), "R3");
        chk(rd_cnt[3] == 8 && bcnt[3] == 0, "R7", "backing reads for pool 3", rd_cnt[3], 8);
        acquire_fail(3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        acquire_fail(2);
        t_lifo();
        t_arb();
        t_depletion();
        t_spill_refill();
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule